// File: doc/BRIEF.md
# BCD Window Comparator Bank

This block keeps sixteen numeric windows. Each window has a lower and an upper bound, and every bound is a four-digit BCD word. When the evaluate strobe is high, the block compares a BCD present value against all sixteen windows in parallel. It then loads a 16-bit result word in which bit n reports whether the value lies inside window n, with both bounds counted as inside.

Software or a sequencer writes the bounds through a plain register write port. Window n takes its lower bound at address 2n and its upper bound at address 2n+1. A typical source for the compared value is a free-running BCD event counter. The strobe marks the moments at which the result should follow that counter. Between strobes the result word does not change.

More than sixteen outputs are available by placing several instances side by side. All instances share the same value, and each instance drives its own result word.

Top module: `bcd_window_bank`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at `wr_addr`. Address 2n is the lower bound of window n, address 2n+1 is its upper bound, and window n drives `result[n]`. Other windows are not affected.
- R2: Bounds are inclusive. `result[n]` is 1 after an evaluation when lower(n) <= value <= upper(n), and 0 otherwise.
- R3: An evaluation happens at the rising edge at which `eval` is high. The new result is visible after that edge. It uses the bounds as they stood before that edge, so a write in the same cycle counts only for later evaluations.
- R4: While `eval` is low, `result` keeps its value, including while bounds are being written.
- R5: A window whose lower bound is 0000 turns on when a value of 0000 is evaluated, for example right after the counter has been cleared.
- R6: Bounds and value are compared as unsigned 16-bit patterns. For valid BCD this ordering is the decimal ordering. Non-BCD patterns are accepted, are ordered by the same rule, and raise no error indication.
- R7: A synchronous active-low reset clears `result` to 0 and every bound to 0000.
- R8: Windows are independent. Overlapping windows can report on together in a single evaluation.
- R9: A window whose lower bound exceeds its upper bound never reports on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bound write enable |
| wr_addr | input | 5 | Bound address: 2n lower, 2n+1 upper of window n |
| wr_data | input | 16 | Bound value, four BCD digits |
| eval | input | 1 | Evaluate strobe |
| value | input | 16 | Present value, four BCD digits |
| result | output | 16 | Window hit word, bit n for window n |

## Verification
The result word is the only observable state, so a corrupted bound stays hidden until the next evaluation whose value falls between the correct bound and the wrong one. The bench therefore places values exactly on, just below and just above bounds. A wrong hold or update decision shows on the very next clock as a changed or unchanged word. The bench compares the whole word against its model after every clock, so either kind of fault appears within one cycle of the stimulus that exposes it.

// File: rtl/bwc_pkg.sv
// Package: shared sizing for the BCD window comparator bank.
// Assumes four bits per BCD digit.
package bwc_pkg;
    parameter int WIN_COUNT  = 16;
    parameter int BCD_DIGITS = 4;
    localparam int VAL_W  = BCD_DIGITS * 4;
    localparam int ADDR_W = $clog2(2 * WIN_COUNT);
endpackage

// File: rtl/bwc_limit_store.sv
// Module: bwc_limit_store
// Holds one lower and one upper bound per window. The address LSB picks
// lower (0) or upper (1); the remaining bits pick the window. Addresses
// that name no window are dropped. Assumes the writer keeps bounds stable
// while it expects meaningful evaluations.
module bwc_limit_store #(
    parameter int N  = 16,
    parameter int W  = 16,
    parameter int AW = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [W-1:0]        wr_data,
    output logic [N-1:0][W-1:0] lo_o,
    output logic [N-1:0][W-1:0] hi_o
);

    for (genvar g = 0; g < N; g++) begin : g_win
        localparam logic [AW-1:0] LO_ADDR = AW'(2 * g);
        localparam logic [AW-1:0] HI_ADDR = AW'(2 * g + 1);

        logic lo_sel;
        logic hi_sel;

        // Decode this window's two addresses.
        always_comb begin
            lo_sel = wr_en && (wr_addr == LO_ADDR);
            hi_sel = wr_en && (wr_addr == HI_ADDR);
        end

        // Lower bound register.
        always_ff @(posedge clk) begin
            if (!rst_n)      lo_o[g] <= '0;
            else if (lo_sel) lo_o[g] <= wr_data;
        end

        // Upper bound register.
        always_ff @(posedge clk) begin
            if (!rst_n)      hi_o[g] <= '0;
            else if (hi_sel) hi_o[g] <= wr_data;
        end

        p_lo_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == LO_ADDR) |=> lo_o[g] == $past(wr_data));
        p_hi_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == HI_ADDR) |=> hi_o[g] == $past(wr_data));
        p_lo_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_addr != LO_ADDR || !wr_en) |=> $stable(lo_o[g]));
    end

endmodule

// File: rtl/bwc_compare.sv
// Module: bwc_compare
// Combinational inclusive window test for every window. USE_DIGITS=1
// builds a digit-by-digit magnitude compare, most significant digit first.
// USE_DIGITS=0 compares the whole raw word. Both give the same ordering
// because nibbles weigh by position.
module bwc_compare #(
    parameter int N          = 16,
    parameter int DIGITS     = 4,
    parameter bit USE_DIGITS = 1'b0,
    localparam int W         = DIGITS * 4
) (
    input  logic [W-1:0]        value,
    input  logic [N-1:0][W-1:0] lo_i,
    input  logic [N-1:0][W-1:0] hi_i,
    output logic [N-1:0]        hit_o
);

    // a <= b, decided at the highest digit position where a and b differ.
    function automatic logic le_digits(input logic [W-1:0] a, input logic [W-1:0] b);
        logic decided;
        logic res;
        decided = 1'b0;
        res     = 1'b1;
        for (int d = DIGITS - 1; d >= 0; d--) begin
            if (!decided && (a[d*4 +: 4] != b[d*4 +: 4])) begin
                decided = 1'b1;
                res     = a[d*4 +: 4] < b[d*4 +: 4];
            end
        end
        return res;
    endfunction

    for (genvar g = 0; g < N; g++) begin : g_cmp
        if (USE_DIGITS) begin : g_digit
            // Digit-serial bounds test.
            always_comb hit_o[g] = le_digits(lo_i[g], value) && le_digits(value, hi_i[g]);
        end else begin : g_raw
            // Raw-pattern bounds test.
            always_comb hit_o[g] = (lo_i[g] <= value) && (value <= hi_i[g]);
        end
    end

endmodule

// File: rtl/bwc_result_reg.sv
// Module: bwc_result_reg
// Captures the hit vector when the evaluate strobe is high and holds it
// otherwise. Assumes the hit vector has settled within one cycle.
module bwc_result_reg #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         eval,
    input  logic [N-1:0] hit_i,
    output logic [N-1:0] result_o
);

    // Load on strobe, hold between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)    result_o <= '0;
        else if (eval) result_o <= hit_i;
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |=> $stable(result_o));
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> result_o == '0);

endmodule

// File: rtl/bcd_window_bank.sv
// Module: bcd_window_bank (top)
// Sixteen inclusive BCD windows, written through a flat register port and
// evaluated against a present value on a strobe. No BCD validity checks
// are made; bounds are ordered as raw unsigned patterns.
module bcd_window_bank
    import bwc_pkg::*;
#(
    parameter int N          = WIN_COUNT,
    parameter int DIGITS     = BCD_DIGITS,
    parameter bit USE_DIGITS = 1'b1,
    localparam int W         = DIGITS * 4,
    localparam int AW        = $clog2(2 * N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          eval,
    input  logic [W-1:0]  value,
    output logic [N-1:0]  result
);

    logic [N-1:0][W-1:0] lo_w;
    logic [N-1:0][W-1:0] hi_w;
    logic [N-1:0]        hit_w;

    bwc_limit_store #(.N(N), .W(W), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .lo_o    (lo_w),
        .hi_o    (hi_w)
    );

    bwc_compare #(.N(N), .DIGITS(DIGITS), .USE_DIGITS(USE_DIGITS)) u_cmp (
        .value (value),
        .lo_i  (lo_w),
        .hi_i  (hi_w),
        .hit_o (hit_w)
    );

    bwc_result_reg #(.N(N)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .eval     (eval),
        .hit_i    (hit_w),
        .result_o (result)
    );

    for (genvar g = 0; g < N; g++) begin : g_chk
        p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (eval && value == '0 && lo_w[g] == '0) |=> result[g]);
        p_inverted_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (eval && lo_w[g] > hi_w[g]) |=> !result[g]);
        p_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (eval && value < lo_w[g]) |=> !result[g]);
    end

endmodule

// File: tb/sim_bcd_window_bank.sv
module sim_bcd_window_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        eval = 1'b0;
    logic [15:0] value = '0;
    logic [15:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    int          m_lo [16];
    int          m_hi [16];
    logic [15:0] m_res;

    always #2 clk = ~clk;

    bcd_window_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .eval(eval), .value(value), .result(result)
    );

    function automatic logic [15:0] to_bcd(input int v);
        logic [15:0] b;
        for (int d = 0; d < 4; d++) begin
            b[d*4 +: 4] = 4'((v / (10 ** d)) % 10);
        end
        return b;
    endfunction

    task automatic check(input logic [15:0] exp, input string tag);
        n_checks++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s: result=%h expected=%h", tag, result, exp);
        end
    endtask

    // One clock: drive, update the reference at the edge, compare just after.
    task automatic step(input logic we, input int addr, input logic [15:0] data,
                        input logic ev, input logic [15:0] val, input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = 5'(addr); wr_data = data; eval = ev; value = val;
        @(posedge clk);
        if (ev) begin
            for (int n = 0; n < 16; n++)
                m_res[n] = (m_lo[n] <= int'(val)) && (int'(val) <= m_hi[n]);
        end
        if (we) begin
            if (addr[0]) m_hi[addr >> 1] = int'(data);
            else         m_lo[addr >> 1] = int'(data);
        end
        #1;
        check(m_res, tag);
        @(negedge clk);
        wr_en = 1'b0; eval = 1'b0;
    endtask

    task automatic put(input int addr, input int dec, input string tag);
        step(1'b1, addr, to_bcd(dec), 1'b0, 16'h0, tag);
    endtask

    task automatic ev(input int dec, input string tag);
        step(1'b0, 0, 16'h0, 1'b1, to_bcd(dec), tag);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: result=%h expected=end of run", result);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int n = 0; n < 16; n++) begin m_lo[n] = 0; m_hi[n] = 0; end
        m_res = '0;
        repeat (3) @(posedge clk);
        #1;
        check(16'h0000, "R7 reset result");
        @(negedge clk);
        rst_n = 1'b1;
        // R7: bounds cleared to 0000, so value 0 hits every window.
        ev(0, "R7 bounds zero R5");
        ev(1, "R7 value one misses");
        // R4/R1: program overlapping windows without evaluating.
        for (int n = 0; n < 16; n++) begin
            put(2 * n, n * 500, "R4 hold during write R1");
            put(2 * n + 1, n * 500 + 600, "R4 hold during write R1");
        end
        // R2/R8: bounds and overlap.
        ev(0, "R5 zero lower");
        ev(499, "R2 R8 overlap");
        ev(500, "R2 on lower");
        ev(600, "R2 on upper");
        ev(601, "R2 above upper");
        ev(8099, "R2 R8 mid");
        ev(8100, "R2 top upper");
        ev(8101, "R2 above top");
        ev(9999, "R2 max value");
        // R4: hold while idle.
        step(1'b0, 0, 16'h0, 1'b0, to_bcd(1234), "R4 idle hold");
        // R1: a single address touches a single bound.
        put(11, 9999, "R1 upper of window 5");
        ev(9000, "R1 window 5 only");
        put(20, 0, "R1 lower of window 10");
        ev(300, "R1 window 10");
        // R3: write and evaluate in the same cycle.
        step(1'b1, 0, to_bcd(100), 1'b1, to_bcd(50), "R3 old bound used");
        ev(50, "R3 new bound used");
        // R9: inverted window.
        put(6, 5000, "R9 setup");
        put(7, 4000, "R9 setup");
        ev(4500, "R9 inverted off");
        ev(5000, "R9 inverted at lower");
        // R6: non-BCD patterns as raw unsigned.
        step(1'b1, 30, 16'h00A0, 1'b0, 16'h0, "R6 setup");
        step(1'b1, 31, 16'h00FF, 1'b0, 16'h0, "R6 setup");
        step(1'b0, 0, 16'h0, 1'b1, 16'h00B5, "R6 raw inside");
        step(1'b0, 0, 16'h0, 1'b1, 16'h0099, "R6 raw below");
        step(1'b0, 0, 16'h0, 1'b1, 16'hFFFF, "R6 raw top");
        // R5: counter cleared to zero again.
        ev(0, "R5 after clear");
        // R7: reset mid-run clears result and bounds.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        for (int n = 0; n < 16; n++) begin m_lo[n] = 0; m_hi[n] = 0; end
        m_res = '0;
        check(16'h0000, "R7 mid reset");
        @(negedge clk);
        rst_n = 1'b1;
        ev(0, "R7 bounds cleared");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule